// File: doc/BRIEF.md
# Socket Receive Drain Sequencer

This block empties one socket's receive buffer on an attached network controller. It sits above a single-byte frame master. Each register or buffer byte costs one request/grant transaction on that master. A pulse on `start` begins a drain.

The block first reads the 16-bit received-size register. It keeps reading until two back-to-back reads agree, so a value caught while it is changing is never used. If nothing is waiting, it reports done at once. Otherwise it reads the 16-bit read pointer and streams that many bytes out on a valid/ready byte port, fetching each one from the buffer offset the advanced pointer gives. It then writes back the pointer advanced by the byte count. Last, it writes the receive command, which tells the controller the space is free for new data.

The host sees a one-cycle `done` pulse only once the command write has been granted.

Top module: `rx_drain_seq`

## Requirements
- R1: While and after reset, `done`, `req` and `out_valid` are low.
- R2: The size is read as the high byte at `SIZE_REG`, then the low byte at `SIZE_REG+1`. Reads of whole pairs repeat until two consecutive pairs return the same value.
- R3: A size of zero raises `done` without any buffer read, pointer write or command write.
- R4: After the size, the pointer is read (high byte at `PTR_REG`, low byte at `PTR_REG+1`). Exactly `size` bytes are then output in order, byte i being the buffer byte at offset `(ptr+i) mod BUF_BYTES`.
- R5: After the last byte is accepted, `(ptr+size) mod 2^16` is written: high byte to `PTR_REG`, then low byte to `PTR_REG+1`.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` is held. No buffer read is requested while a byte is pending.
- R7: After the pointer write, the value 0x40 is written to `CMD_REG`. `done` pulses for one cycle only after that write's grant.
- R8: A request keeps `req_wr`, `req_buf` and `req_addr` stable until `gnt`. `req_buf`=1 selects the receive buffer and 0 the socket registers. Buffer addresses stay below `BUF_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a drain (ignored while busy) |
| done | output | 1 | One-cycle completion pulse |
| req | output | 1 | Transaction request to frame master |
| req_wr | output | 1 | 1 = write, 0 = read |
| req_buf | output | 1 | 1 = receive buffer, 0 = socket register |
| req_addr | output | 16 | Register address or buffer offset |
| req_wdata | output | 8 | Write byte |
| gnt | input | 1 | Transaction complete, one cycle |
| gnt_rdata | input | 8 | Read byte, valid with `gnt` |
| out_data | output | 8 | Drained byte |
| out_valid | output | 1 | `out_data` is valid |
| out_ready | input | 1 | Consumer accepts the byte |

## Verification
The drain is tried with several patterns, each aimed at one kind of fault:
- A steady consumer.
- A consumer ready every other cycle.
- A consumer ready one cycle in four, which shows whether the byte is held and whether fetches stall.
- A read pointer near 0xFFFF, which separates modulo-2^16 write-back from a wider sum.
- A pointer near the buffer end, which checks the offset masking.
- One and two unstable size reads, which show whether the repeat-until-agree rule is counted correctly.
- A zero size, which tells the skip path apart from a drain of length zero that still frees space.

// File: rtl/rx_drain_seq.sv
module rx_drain_seq #(
  parameter int unsigned BUF_BYTES = 2048,
  parameter logic [15:0] SIZE_REG  = 16'h0026,
  parameter logic [15:0] PTR_REG   = 16'h0028,
  parameter logic [15:0] CMD_REG   = 16'h0001,
  parameter logic [7:0]  RECV_CMD  = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        done,
  output logic        req,
  output logic        req_wr,
  output logic        req_buf,
  output logic [15:0] req_addr,
  output logic [7:0]  req_wdata,
  input  logic        gnt,
  input  logic [7:0]  gnt_rdata,
  output logic [7:0]  out_data,
  output logic        out_valid,
  input  logic        out_ready
);
  localparam logic [15:0] MASK = 16'(BUF_BYTES - 1);

  typedef enum logic [3:0] {IDLE, SZ_H, SZ_L, RP_H, RP_L, DRAIN, WP_H, WP_L, CMD} st_t;
  st_t st;

  logic [7:0]  hi;
  logic [15:0] prev, size, ptr, cnt;
  logic        have_prev;

  wire         fire    = req && gnt;
  wire  [15:0] rd16    = {hi, gnt_rdata};
  wire  [15:0] new_ptr = ptr + size;

  assign req     = (st != IDLE) && (st != DRAIN || (cnt != size && !out_valid));
  assign req_wr  = (st == WP_H) || (st == WP_L) || (st == CMD);
  assign req_buf = (st == DRAIN);

  always_comb begin
    req_addr  = 16'h0;
    req_wdata = 8'h0;
    case (st)
      SZ_H:  req_addr = SIZE_REG;
      SZ_L:  req_addr = SIZE_REG + 16'd1;
      RP_H:  req_addr = PTR_REG;
      RP_L:  req_addr = PTR_REG + 16'd1;
      DRAIN: req_addr = (ptr + cnt) & MASK;
      WP_H:  begin req_addr = PTR_REG;         req_wdata = new_ptr[15:8]; end
      WP_L:  begin req_addr = PTR_REG + 16'd1; req_wdata = new_ptr[7:0];  end
      CMD:   begin req_addr = CMD_REG;         req_wdata = RECV_CMD;      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; done <= 1'b0; out_valid <= 1'b0; out_data <= 8'h0;
      hi <= 8'h0; prev <= 16'h0; size <= 16'h0; ptr <= 16'h0; cnt <= 16'h0;
      have_prev <= 1'b0;
    end else begin
      done <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (st)
        IDLE: if (start) begin have_prev <= 1'b0; cnt <= 16'h0; st <= SZ_H; end
        SZ_H: if (fire) begin hi <= gnt_rdata; st <= SZ_L; end
        SZ_L: if (fire) begin
          if (have_prev && rd16 == prev) begin
            size <= rd16;
            if (rd16 == 16'h0) begin done <= 1'b1; st <= IDLE; end
            else st <= RP_H;
          end else begin
            prev <= rd16; have_prev <= 1'b1; st <= SZ_H;
          end
        end
        RP_H: if (fire) begin hi <= gnt_rdata; st <= RP_L; end
        RP_L: if (fire) begin ptr <= rd16; st <= DRAIN; end
        DRAIN:
          if (fire) begin
            out_data <= gnt_rdata; out_valid <= 1'b1; cnt <= cnt + 16'd1;
          end else if (cnt == size && !out_valid) st <= WP_H;
        WP_H: if (fire) st <= WP_L;
        WP_L: if (fire) st <= CMD;
        CMD:  if (fire) begin done <= 1'b1; st <= IDLE; end
        default: st <= IDLE;
      endcase
    end
  end

  p_quiet_reset_r1: assert property (@(posedge clk) $past(!rst_n) |-> !done && !req && !out_valid);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req && !gnt |=> req && $stable(req_addr) && $stable(req_wr) && $stable(req_buf));
  p_buf_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req && req_buf |-> req_addr < 16'(BUF_BYTES));
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_no_fetch_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req && req_buf |-> !out_valid);
  p_cmd_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req && req_wr && req_addr == CMD_REG |-> req_wdata == RECV_CMD);
  p_done_after_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(gnt && !req_buf && (req_wr ? req_addr == CMD_REG : req_addr == SIZE_REG + 16'd1)));
endmodule

// File: tb/rx_drain_seq_tb.sv
module rx_drain_seq_tb;
  localparam int BUF = 2048;
  localparam logic [15:0] SZR = 16'h0026, PTR = 16'h0028, CMDR = 16'h0001;

  logic clk = 0, rst_n = 0, start = 0, gnt = 0, out_ready = 0;
  logic [7:0] gnt_rdata = 0;
  logic done, req, req_wr, req_buf, out_valid;
  logic [15:0] req_addr;
  logic [7:0] req_wdata, out_data;

  rx_drain_seq u_dut (.clk, .rst_n, .start, .done, .req, .req_wr, .req_buf, .req_addr,
    .req_wdata, .gnt, .gnt_rdata, .out_data, .out_valid, .out_ready);

  always #5 clk = ~clk;

  int errs = 0, checks = 0;
  logic [15:0] v_size, v_ptr;
  int v_mode, v_glitch;
  int szh, szl, rph, rpl, bufrd, wp_cnt, cmd_cnt, order_err, bad_acc, stall_err;
  int got, byte_err, hold_err, done_cnt;
  logic [7:0] wp_hi, wp_lo, cmd_val, held;
  logic pend;

  // {size, ptr, ready mode, unstable size pairs}
  localparam logic [35:0] VEC [6] = '{
    {16'd5,  16'h0010, 2'd0, 2'd0},
    {16'd3,  16'hFFFE, 2'd1, 2'd0},
    {16'd4,  16'h07FE, 2'd2, 2'd1},
    {16'd1,  16'h1234, 2'd0, 2'd2},
    {16'd0,  16'h0040, 2'd0, 2'd0},
    {16'd20, 16'h0100, 2'd1, 2'd1}};

  function automatic logic [7:0] bufbyte(logic [15:0] off);
    return off[7:0] ^ 8'h5A ^ {5'd0, off[10:8]};
  endfunction

  function automatic logic [15:0] szval(int p);
    return (p < v_glitch) ? v_size + 16'h1000 * 16'(p + 1) : v_size;
  endfunction

  task automatic chk(bit ok, string r, string what, int act, int exp);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp); end
  endtask

  initial begin : responder
    forever begin
      @(posedge clk);
      if (gnt) gnt <= 1'b0;
      else if (req) begin
        gnt <= 1'b1;
        gnt_rdata <= 8'h00;
        if (req_buf) begin
          bufrd++;
          if (out_valid) stall_err++;
          if (req_wr) bad_acc++;
          gnt_rdata <= bufbyte(req_addr);
        end else if (!req_wr && req_addr == SZR) begin
          gnt_rdata <= szval(szh)[15:8]; szh++;
        end else if (!req_wr && req_addr == SZR + 1) begin
          gnt_rdata <= szval(szh - 1)[7:0]; szl++;
        end else if (!req_wr && req_addr == PTR) begin
          gnt_rdata <= v_ptr[15:8]; rph++;
        end else if (!req_wr && req_addr == PTR + 1) begin
          gnt_rdata <= v_ptr[7:0]; rpl++;
        end else if (req_wr && req_addr == PTR) begin
          wp_hi <= req_wdata; if (wp_cnt != 0 || got != v_size) order_err++; wp_cnt++;
        end else if (req_wr && req_addr == PTR + 1) begin
          wp_lo <= req_wdata; if (wp_cnt != 1) order_err++; wp_cnt++;
        end else if (req_wr && req_addr == CMDR) begin
          cmd_val <= req_wdata; if (wp_cnt != 2) order_err++; cmd_cnt++;
        end else bad_acc++;
      end
    end
  end

  int rc = 0;
  initial begin : ready_drv
    forever begin
      @(posedge clk);
      rc++;
      out_ready <= (v_mode == 0) ? 1'b1 : (v_mode == 1) ? rc[0] : (rc[1:0] == 2'd3);
    end
  end

  initial begin : consumer
    pend = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pend && out_data != held) hold_err++;
        if (done) begin done_cnt++; if (v_size != 0 && cmd_cnt != 1) order_err++; end
        if (out_valid && out_ready) begin
          if (out_data != bufbyte((v_ptr + 16'(got)) & 16'(BUF - 1))) byte_err++;
          got++;
        end
        pend = out_valid && !out_ready;
        held = out_data;
      end
    end
  end

  initial begin : watchdog
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic clear();
    szh = 0; szl = 0; rph = 0; rpl = 0; bufrd = 0; wp_cnt = 0; cmd_cnt = 0; order_err = 0;
    bad_acc = 0; stall_err = 0; got = 0; byte_err = 0; hold_err = 0; done_cnt = 0;
  endtask

  task automatic run_drain();
    int t;
    clear();
    @(posedge clk); start <= 1'b1;
    @(posedge clk); start <= 1'b0;
    t = 0;
    while (done_cnt == 0 && t < 5000) begin @(posedge clk); t++; end
    repeat (4) @(posedge clk);
  endtask

  initial begin
    logic [15:0] np;
    v_size = 0; v_ptr = 0; v_mode = 0; v_glitch = 0;
    clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!done && !req && !out_valid, "R1", "outputs in reset", {done, req, out_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!done && !req && !out_valid, "R1", "outputs after reset", {done, req, out_valid}, 0);

    foreach (VEC[i]) begin
      {v_size, v_ptr} = VEC[i][35:4];
      v_mode = int'(VEC[i][3:2]);
      v_glitch = int'(VEC[i][1:0]);
      run_drain();
      np = v_ptr + v_size;
      chk(done_cnt == 1, "R7", "done pulses", done_cnt, 1);
      chk(szh == v_glitch + 2 && szl == szh, "R2", "size pair reads", szh, v_glitch + 2);
      chk(bad_acc == 0, "R8", "unexpected accesses", bad_acc, 0);
      if (v_size == 0) begin
        chk(bufrd == 0 && wp_cnt == 0 && cmd_cnt == 0 && rph == 0, "R3", "traffic on empty",
            bufrd + wp_cnt + cmd_cnt + rph, 0);
      end else begin
        chk(rph == 1 && rpl == 1, "R4", "pointer reads", rph + rpl, 2);
        chk(got == v_size && bufrd == v_size, "R4", "bytes streamed", got, v_size);
        chk(byte_err == 0, "R4", "byte value mismatches", byte_err, 0);
        chk({wp_hi, wp_lo} == np && wp_cnt == 2, "R5", "pointer written", {wp_hi, wp_lo}, np);
        chk(cmd_cnt == 1 && cmd_val == 8'h40, "R7", "receive command", cmd_val, 8'h40);
        chk(order_err == 0, "R7", "sequence order errors", order_err, 0);
        chk(stall_err == 0 && hold_err == 0, "R6", "stall/hold errors", stall_err + hold_err, 0);
      end
    end

    // directed: start held high during a drain is ignored, exactly one drain done
    v_size = 16'd2; v_ptr = 16'h07FF; v_mode = 2; v_glitch = 0;
    clear();
    @(posedge clk); start <= 1'b1;
    repeat (6) @(posedge clk); start <= 1'b0;
    repeat (200) @(posedge clk);
    chk(done_cnt == 1 && szh == 2, "R2", "start while busy", done_cnt, 1);
    chk(byte_err == 0 && got == 2, "R4", "wrap at buffer end", got, 2);
    chk({wp_hi, wp_lo} == 16'h0801, "R5", "pointer past buffer size", {wp_hi, wp_lo}, 16'h0801);

    // directed: reset in mid drain returns to quiet state
    v_size = 16'd30; v_ptr = 0; v_mode = 2; clear();
    @(posedge clk); start <= 1'b1;
    @(posedge clk); start <= 1'b0;
    repeat (40) @(posedge clk);
    rst_n <= 1'b0;
    @(posedge clk); @(negedge clk);
    chk(!done && !req && !out_valid, "R1", "reset mid drain", {done, req, out_valid}, 0);
    rst_n <= 1'b1;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule